// File: doc/BRIEF.md
# Byte Significance Compressor and Expander

This block shrinks 32-bit words by keeping only the bytes that carry information and writing a short extension code that says which bytes were dropped. A byte is dropped when it is nothing more than the sign extension of the byte below it, meaning all zeros or all ones matching that lower byte's top bit. The kept bytes leave the block packed toward the low end of a 32-bit lane. A separate expander path takes a packed word and its code and rebuilds the full 32-bit value.

Two codes are offered, chosen per word by a mode input. Value mode suits two's-complement integers. It uses a 2-bit count of kept low-order bytes, so only high-order bytes can be dropped. Pointer mode suits addresses. It uses one flag per upper byte, so a run of zero or one bytes in the middle of a word can be dropped as well as the bytes at the top. Both paths are combinational. A parameter adds one register stage on every output.

Top module: `sigcomp`

## Requirements
- R1: In value mode (mode_in = 0), the compressor keeps the smallest count n of low-order bytes whose sign extension equals word_in exactly. ext_out[1:0] is 11 for n=1, 10 for n=2, 01 for n=3 and 00 for n=4, and ext_out[2] is 0. Examples: 0x00000004 gives 11, and 0xFFFFF504 gives 10.
- R2: In value mode, packed_out holds the n kept bytes in their original order with byte 0 in bits [7:0], and every byte lane at or above n is zero.
- R3: In pointer mode (mode_in = 1), ext_out[k-1] for k = 1..3 is 1 exactly when byte k of word_in equals eight copies of bit 7 of byte k-1. Examples: 0x10000009 gives 011, and 0xFFE70004 gives 101.
- R4: In pointer mode, byte 0 is always kept. Every byte k whose flag is 0 is also kept. The kept bytes are packed from lane 0 upward in ascending byte order, and the lanes above them are zero. Examples: 0x10000009 packs to 0x00001009, and 0xFFE70004 packs to 0x0000E704.
- R5: In value mode (cmp_mode_in = 0), the expander takes n from cmp_ext_in[1:0] using the R1 encoding. It copies packed lanes 0..n-1 into bytes 0..n-1 of word_out and fills each higher byte with copies of bit 7 of the byte below it. cmp_ext_in[2] is ignored.
- R6: In pointer mode (cmp_mode_in = 1), the expander rebuilds the word from byte 0 upward. A byte whose flag is 1 becomes eight copies of bit 7 of the already rebuilt byte below it. A byte whose flag is 0 takes the next unused packed lane.
- R7: For both modes, expanding the compressor's own packed_out and ext_out returns the original word_in.
- R8: With REG_OUT = 1, every output changes one clock edge after its inputs change, and reset (rst_n low) forces all outputs to zero. With REG_OUT = 0, the outputs are purely combinational.
- R9: Packed lanes beyond the number of bytes the code says were kept have no effect on word_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| mode_in | input | 1 | Compressor mode: 0 value, 1 pointer |
| word_in | input | 32 | Word to compress |
| packed_out | output | 32 | Kept bytes, low-aligned, unused lanes zero |
| ext_out | output | 3 | Extension code of the compressed word |
| cmp_mode_in | input | 1 | Expander mode: 0 value, 1 pointer |
| cmp_ext_in | input | 3 | Extension code to expand |
| cmp_bytes_in | input | 32 | Packed bytes to expand |
| word_out | output | 32 | Rebuilt 32-bit word |

## Verification
The block holds no state other than the output register. A wrong decision, such as a misjudged extension byte or a packing index that is off by one, therefore shows up at the ports on the very next edge. It appears as a wrong code, a shifted lane, or a nonzero lane that should be zero. The sweep combines byte values that sit exactly on the sign boundary (0x7F, 0x80, 0x00, 0xFF) in every position, so each extension decision is driven both ways in every byte position. It also checks that padding in unused lanes never reaches word_out.

// File: rtl/sigcomp.sv
module sigcomp #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_in,
  input  logic [31:0] word_in,
  output logic [31:0] packed_out,
  output logic [2:0]  ext_out,
  input  logic        cmp_mode_in,
  input  logic [2:0]  cmp_ext_in,
  input  logic [31:0] cmp_bytes_in,
  output logic [31:0] word_out
);
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int WW = NB * BW;
  localparam int EW = NB - 1;

  function automatic logic [NB-1:0] keep_mask(input logic pmode, input logic [EW-1:0] ext);
    logic [NB-1:0] m;
    if (pmode) m = {~ext, 1'b1};
    else begin
      case (ext[1:0])
        2'b11:   m = 4'b0001;
        2'b10:   m = 4'b0011;
        2'b01:   m = 4'b0111;
        default: m = 4'b1111;
      endcase
    end
    return m;
  endfunction

  function automatic logic [WW-1:0] pack(input logic [WW-1:0] w, input logic [NB-1:0] m);
    logic [WW-1:0] o;
    int idx;
    o = '0;
    idx = 0;
    for (int j = 0; j < NB; j++) begin
      if (m[j]) begin
        o[idx*BW +: BW] = w[j*BW +: BW];
        idx++;
      end
    end
    return o;
  endfunction

  function automatic logic [WW-1:0] unpack(input logic [WW-1:0] p, input logic [NB-1:0] m);
    logic [WW-1:0] o;
    int idx;
    o = '0;
    idx = 0;
    for (int j = 0; j < NB; j++) begin
      if (m[j] || j == 0) begin
        o[j*BW +: BW] = p[idx*BW +: BW];
        idx++;
      end else begin
        o[j*BW +: BW] = {BW{o[j*BW-1]}};
      end
    end
    return o;
  endfunction

  logic [EW:1]    sx;
  logic [EW-1:0]  c_ext;
  logic [NB-1:0]  c_mask;
  logic [WW-1:0]  c_packed;
  logic [WW-1:0]  d_word;

  for (genvar k = 1; k < NB; k++) begin : g_sx
    assign sx[k] = (word_in[k*BW +: BW] == {BW{word_in[k*BW-1]}});
  end

  always_comb begin
    if (mode_in) c_ext = sx;
    else if (sx[3] && sx[2] && sx[1]) c_ext = 3'b011;
    else if (sx[3] && sx[2])          c_ext = 3'b010;
    else if (sx[3])                   c_ext = 3'b001;
    else                              c_ext = 3'b000;
  end

  assign c_mask   = keep_mask(mode_in, c_ext);
  assign c_packed = pack(word_in, c_mask);
  assign d_word   = unpack(cmp_bytes_in, keep_mask(cmp_mode_in, cmp_ext_in));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        packed_out <= '0;
        ext_out    <= '0;
        word_out   <= '0;
      end else begin
        packed_out <= c_packed;
        ext_out    <= c_ext;
        word_out   <= d_word;
      end
    end
  end else begin : g_comb
    assign packed_out = c_packed;
    assign ext_out    = c_ext;
    assign word_out   = d_word;
  end

  always_comb begin
    if (rst_n) begin
      assert_roundtrip_R7: assert (unpack(c_packed, keep_mask(mode_in, c_ext)) == word_in);
      assert_byte0_kept_R4: assert (c_packed[BW-1:0] == word_in[BW-1:0]);
      assert_minimal_count_R1: assert (mode_in || c_ext[1:0] == 2'b11 ||
        word_in[(NB-c_ext[1:0])*BW-1 -: BW] != {BW{word_in[(NB-c_ext[1:0]-1)*BW-1]}});
      assert_unused_lanes_zero_R2: assert (($countones(c_mask) == NB) ||
        ((c_packed >> ($countones(c_mask) * BW)) == '0));
    end
  end
endmodule

// File: tb/sigcomp_bench.sv
module sigcomp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_in = 1'b0;
  logic [31:0] word_in = '0;
  logic [31:0] packed_out;
  logic [2:0]  ext_out;
  logic        cmp_mode_in = 1'b0;
  logic [2:0]  cmp_ext_in = '0;
  logic [31:0] cmp_bytes_in = '0;
  logic [31:0] word_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sigcomp #(.REG_OUT(1'b1)) u_sigcomp (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .word_in(word_in),
    .packed_out(packed_out), .ext_out(ext_out), .cmp_mode_in(cmp_mode_in),
    .cmp_ext_in(cmp_ext_in), .cmp_bytes_in(cmp_bytes_in), .word_out(word_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int data_count(input logic [31:0] w);
    for (int k = 1; k < 4; k++) begin
      int sh = 32 - 8 * k;
      if ($signed(w << sh) >>> sh == $signed(w)) return k;
    end
    return 4;
  endfunction

  function automatic logic [3:0] ref_keep(input logic pm, input logic [31:0] w, output logic [2:0] e);
    logic [3:0] m;
    if (pm) begin
      for (int i = 1; i < 4; i++) e[i-1] = (w[8*i +: 8] == (w[8*i-1] ? 8'hFF : 8'h00));
      m = {~e, 1'b1};
    end else begin
      int n = data_count(w);
      e = {1'b0, 2'(4 - n)};
      m = 4'((1 << n) - 1);
    end
    return m;
  endfunction

  initial begin
    logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF, 8'hE7, 8'h10};
    repeat (3) @(negedge clk);
    chk("R8 reset packed", packed_out, 32'h0);
    chk("R8 reset ext", {29'h0, ext_out}, 32'h0);
    chk("R8 reset word", word_out, 32'h0);
    rst_n = 1'b1;

    mode_in = 1'b0; word_in = 32'h00000004;
    @(negedge clk);
    chk("R1 00000004 ext", {29'h0, ext_out}, 32'h3);
    chk("R2 00000004 packed", packed_out, 32'h04);
    word_in = 32'hFFFFF504;
    #2;
    chk("R8 output holds before edge", packed_out, 32'h04);
    @(negedge clk);
    chk("R1 FFFFF504 ext", {29'h0, ext_out}, 32'h2);
    chk("R2 FFFFF504 packed", packed_out, 32'hF504);
    mode_in = 1'b1; word_in = 32'h10000009;
    @(negedge clk);
    chk("R3 10000009 ext", {29'h0, ext_out}, 32'h3);
    chk("R4 10000009 packed", packed_out, 32'h1009);
    word_in = 32'hFFE70004;
    cmp_mode_in = 1'b1; cmp_ext_in = 3'b111; cmp_bytes_in = 32'hABCDEF80;
    @(negedge clk);
    chk("R3 FFE70004 ext", {29'h0, ext_out}, 32'h5);
    chk("R4 FFE70004 packed", packed_out, 32'hE704);
    chk("R6 chained fill", word_out, 32'hFFFFFF80);
    cmp_mode_in = 1'b0; cmp_ext_in = 3'b110; cmp_bytes_in = 32'h12347F80;
    @(negedge clk);
    chk("R5 two bytes, top code bit ignored", word_out, 32'h00007F80);

    for (int pm = 0; pm < 2; pm++) begin
      for (int a = 0; a < 4096; a++) begin
        logic [31:0] w, p, pad;
        logic [3:0] m;
        logic [2:0] e;
        int idx;
        w = {vals[(a >> 9) & 7], vals[(a >> 6) & 7], vals[(a >> 3) & 7], vals[a & 7]};
        m = ref_keep(pm[0], w, e);
        p = '0; pad = '0; idx = 0;
        for (int j = 0; j < 4; j++) if (m[j]) begin p[8*idx +: 8] = w[8*j +: 8]; idx++; end
        for (int j = idx; j < 4; j++) pad[8*j +: 8] = 8'hA5 ^ 8'(a + j);
        mode_in = pm[0]; word_in = w;
        cmp_mode_in = pm[0]; cmp_ext_in = e | (pm[0] ? 3'b000 : 3'b100); cmp_bytes_in = p | pad;
        @(negedge clk);
        chk(pm ? "R3 sweep ext" : "R1 sweep ext", {29'h0, ext_out}, {29'h0, e});
        chk(pm ? "R4 sweep packed" : "R2 sweep packed", packed_out, p);
        chk(pm ? "R6 R9 sweep expand" : "R5 R9 sweep expand", word_out, w);
        cmp_bytes_in = packed_out;
        cmp_ext_in = ext_out;
        @(negedge clk);
        chk("R7 round trip", word_out, w);
      end
    end

    rst_n = 1'b0;
    #2;
    chk("R8 async reset clears", word_out, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule